// File: doc/BRIEF.md
# Signed Word Remainder Unit

This block takes two 64-bit source operands, treats the low 32-bit word of each as a signed two's-complement number, and produces the remainder of dividing the first word by the second. The remainder follows truncating division, so it carries the sign of the dividend. It is sign-extended to fill the whole 64-bit result. Two inputs have no defined answer: a zero divisor, and the most negative word divided by minus one. For both, the unit raises an overflow flag and drives the result to zero.

An operation begins with a one-cycle `start` pulse while the unit is idle. Ordinary operands go through a restoring shift-subtract loop on the operand magnitudes, one quotient bit per cycle, and the sign is applied at the end. The two undefined cases are caught when the operands are captured and finish at once. `done` pulses for one cycle when the result is ready. The result and the flag then hold until the next accepted start.

Top module: `smod_unit`

## Requirements
- R1: The dividend is `src_a[31:0]` and the divisor is `src_b[31:0]`, both read as signed 32-bit two's-complement values.
- R2: A zero divisor gives `ovf` = 1 and `result` = 0.
- R3: A dividend of 0x8000_0000 with a divisor of 0xFFFF_FFFF gives `ovf` = 1 and `result` = 0.
- R4: In every other case, `ovf` = 0 and `result` is the 32-bit signed remainder sign-extended to 64 bits.
- R5: A nonzero remainder has the sign of the dividend, and its magnitude is smaller than the magnitude of the divisor.
- R6: Bits 63..32 of either source have no effect on the result or on the overflow flag, including the zero-divisor test.
- R7: `start` is accepted only while idle. `busy` is high while the loop runs, and `done` is a single-cycle pulse that never overlaps `busy`. In the overflow cases `done` is seen in the first cycle after the accepting clock edge; otherwise it is seen in cycle 33.
- R8: A `start` raised while busy or while `done` is high is ignored. `result` and `ovf` hold their values from `done` until the next accepted start.
- R9: Synchronous reset, at start-up or during an operation, returns the unit to idle with `busy`, `done`, `result` and `ovf` all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an operation when the unit is idle |
| src_a | input | 64 | Source whose low word is the dividend |
| src_b | input | 64 | Source whose low word is the divisor |
| busy | output | 1 | High while the iteration loop runs |
| done | output | 1 | One-cycle pulse when the result is valid |
| result | output | 64 | Sign-extended remainder, or zero on overflow |
| ovf | output | 1 | High for a zero divisor or the most-negative by minus-one case |

## Verification
The bench builds the unit with its default widths: a 64-bit register and a 32-bit word. At these sizes the most negative word (0x8000_0000) and the all-ones divisor can be applied directly, so the overflow case and its near neighbours (most negative by one, by three, and by itself) are all tested. Because the register is twice the word width, the upper halves can carry unrelated patterns. This shows that a divisor which is zero only in its low half still raises overflow. The 32-step loop gives a fixed 33-cycle latency, and start pulses that arrive inside that window are tested to confirm they are ignored.

// File: rtl/smod_pkg.sv
package smod_pkg;

    parameter int unsigned SMOD_XLEN = 64;
    parameter int unsigned SMOD_WLEN = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } smod_state_e;

    // Classification of one operand pair, independent of word width
    typedef struct packed {
        logic div_zero;    // divisor word is zero
        logic min_by_m1;   // most negative dividend with divisor of minus one
        logic dvd_neg;     // dividend word is negative
        logic dsr_neg;     // divisor word is negative
    } smod_flags_t;

    function automatic logic is_special(input smod_flags_t f);
        return f.div_zero | f.min_by_m1;
    endfunction

endpackage

// File: rtl/smod_screen.sv
module smod_screen
    import smod_pkg::*;
#(
    parameter int unsigned WLEN = SMOD_WLEN
) (
    input  logic [WLEN-1:0] dvd_word,
    input  logic [WLEN-1:0] dsr_word,
    output smod_flags_t     flags,
    output logic [WLEN-1:0] dvd_mag,
    output logic [WLEN-1:0] dsr_mag
);
    localparam logic [WLEN-1:0] MOST_NEG = {1'b1, {(WLEN-1){1'b0}}};
    localparam logic [WLEN-1:0] MINUS_ONE = {WLEN{1'b1}};

    always_comb begin
        flags.dvd_neg   = dvd_word[WLEN-1];
        flags.dsr_neg   = dsr_word[WLEN-1];
        flags.div_zero  = (dsr_word == '0);
        flags.min_by_m1 = (dvd_word == MOST_NEG) && (dsr_word == MINUS_ONE);
        dvd_mag = dvd_word[WLEN-1] ? (~dvd_word + 1'b1) : dvd_word;
        dsr_mag = dsr_word[WLEN-1] ? (~dsr_word + 1'b1) : dsr_word;
    end

endmodule

// File: rtl/smod_core.sv
module smod_core
    import smod_pkg::*;
#(
    parameter int unsigned WLEN = SMOD_WLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic [WLEN-1:0] dvd_mag,
    input  logic [WLEN-1:0] dsr_mag,
    output logic [WLEN-1:0] rem_next,
    output logic            last
);
    localparam int unsigned CW = (WLEN > 1) ? $clog2(WLEN) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(WLEN - 1);

    logic [WLEN-1:0] rem_q;
    logic [WLEN-1:0] dvd_q;
    logic [WLEN-1:0] dsr_q;
    logic [CW-1:0]   cnt_q;
    logic [WLEN:0]   shifted;
    logic [WLEN:0]   trial;

    always_comb begin
        shifted  = {rem_q, dvd_q[WLEN-1]};
        trial    = shifted - {1'b0, dsr_q};
        rem_next = trial[WLEN] ? shifted[WLEN-1:0] : trial[WLEN-1:0];
        last     = (cnt_q == LAST_CNT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            dvd_q <= '0;
            dsr_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= '0;
            dvd_q <= dvd_mag;
            dsr_q <= dsr_mag;
            cnt_q <= '0;
        end else if (step) begin
            rem_q <= rem_next;
            dvd_q <= {dvd_q[WLEN-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: every partial remainder stays below the divisor magnitude
    p_partial_bound_r5: assert property (@(posedge clk) disable iff (rst)
        step |-> (rem_next < dsr_q));

    // R8: the divisor is not disturbed while stepping
    p_divisor_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> $stable(dsr_q));

endmodule

// File: rtl/smod_fix.sv
module smod_fix
    import smod_pkg::*;
#(
    parameter int unsigned XLEN = SMOD_XLEN,
    parameter int unsigned WLEN = SMOD_WLEN
) (
    input  logic [WLEN-1:0] rem_mag,
    input  logic            neg,
    output logic [XLEN-1:0] full
);
    localparam int unsigned EXT = XLEN - WLEN;

    logic [WLEN-1:0] signed_word;

    always_comb begin
        signed_word = neg ? (~rem_mag + 1'b1) : rem_mag;
        full = {{EXT{signed_word[WLEN-1]}}, signed_word};
    end

endmodule

// File: rtl/smod_unit.sv
module smod_unit
    import smod_pkg::*;
#(
    parameter int unsigned XLEN = SMOD_XLEN,
    parameter int unsigned WLEN = SMOD_WLEN
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result,
    output logic            ovf
);
    smod_state_e     state_q;
    smod_flags_t     flags;
    logic [WLEN-1:0] dvd_mag;
    logic [WLEN-1:0] dsr_mag;
    logic [WLEN-1:0] rem_next;
    logic            last;
    logic            accept;
    logic            special;
    logic            neg_q;
    logic [XLEN-1:0] fixed;
    logic [XLEN-1:0] result_q;
    logic            ovf_q;
    logic            unused_hi;

    assign unused_hi = ^{src_a[XLEN-1:WLEN], src_b[XLEN-1:WLEN]};

    smod_screen #(.WLEN(WLEN)) u_screen (
        .dvd_word (src_a[WLEN-1:0]),
        .dsr_word (src_b[WLEN-1:0]),
        .flags    (flags),
        .dvd_mag  (dvd_mag),
        .dsr_mag  (dsr_mag)
    );

    assign special = is_special(flags);
    assign accept  = (state_q == ST_IDLE) && start;

    smod_core #(.WLEN(WLEN)) u_core (
        .clk      (clk),
        .rst      (rst),
        .load     (accept && !special),
        .step     (state_q == ST_RUN),
        .dvd_mag  (dvd_mag),
        .dsr_mag  (dsr_mag),
        .rem_next (rem_next),
        .last     (last)
    );

    smod_fix #(.XLEN(XLEN), .WLEN(WLEN)) u_fix (
        .rem_mag (rem_next),
        .neg     (neg_q),
        .full    (fixed)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            neg_q    <= 1'b0;
            result_q <= '0;
            ovf_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    if (special) begin
                        result_q <= '0;
                        ovf_q    <= 1'b1;
                        state_q  <= ST_DONE;
                    end else begin
                        neg_q   <= flags.dvd_neg;
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: if (last) begin
                    result_q <= fixed;
                    ovf_q    <= 1'b0;
                    state_q  <= ST_DONE;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (state_q == ST_RUN);
    assign done   = (state_q == ST_DONE);
    assign result = result_q;
    assign ovf    = ovf_q;

    // R2: an overflow result is always zero
    p_ovf_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (done && ovf) |-> (result == '0));

    // R3: undefined operand pairs finish in the next cycle with overflow
    p_special_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (accept && special) |=> (done && ovf));

    // R5: a nonzero remainder follows the dividend sign
    p_rem_sign_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !ovf && (result != '0)) |-> (result[XLEN-1] == neg_q));

    // R7: done is a single pulse and never overlaps busy
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_busy_done_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R8: outputs hold outside the loop unless a start is accepted
    p_result_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && !accept) |=> ($stable(result) && $stable(ovf)));

endmodule

// File: tb/smod_unit_tb.sv
`timescale 1ns/1ps
module smod_unit_tb;

    localparam int XLEN = 64;
    localparam int WLEN = 32;
    localparam int NVEC = 14;

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] b;
        logic [63:0] r;
        logic        o;
        logic [3:0]  tag;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{64'h0000_0000_0000_0007, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0001, 1'b0, 4'd4}, // R4
        '{64'h0000_0000_FFFF_FFF9, 64'h0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd1}, // R1
        '{64'h0000_0000_0000_0007, 64'h0000_0000_FFFF_FFFD, 64'h0000_0000_0000_0001, 1'b0, 4'd5}, // R5
        '{64'h0000_0000_FFFF_FFF9, 64'h0000_0000_FFFF_FFFD, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'd5}, // R5
        '{64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 64'h0,                   1'b1, 4'd3}, // R3
        '{64'h0000_0000_0000_0005, 64'h0000_0000_0000_0000, 64'h0,                   1'b1, 4'd2}, // R2
        '{64'h0000_0000_8000_0000, 64'h0000_0000_0000_0003, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 4'd5}, // R5
        '{64'h0000_0000_7FFF_FFFF, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF, 1'b0, 4'd4}, // R4
        '{64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000, 64'h0,                   1'b0, 4'd4}, // R4
        '{64'hDEAD_BEEF_0000_000A, 64'h1234_5678_0000_0004, 64'h0000_0000_0000_0002, 1'b0, 4'd6}, // R6
        '{64'h0000_0000_0000_0003, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0003, 1'b0, 4'd4}, // R4
        '{64'h0000_0000_8000_0000, 64'h0000_0000_0000_0001, 64'h0,                   1'b0, 4'd4}, // R4
        '{64'hFFFF_FFFF_8000_0001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   1'b0, 4'd3}, // R3 neighbour
        '{64'h0000_0000_0000_0064, 64'hFFFF_FFFF_0000_0000, 64'h0,                   1'b1, 4'd6}  // R6 zero low half
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [XLEN-1:0] src_a = '0;
    logic [XLEN-1:0] src_b = '0;
    logic            busy;
    logic            done;
    logic [XLEN-1:0] result;
    logic            ovf;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    smod_unit #(.XLEN(XLEN), .WLEN(WLEN)) u_dut (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .src_a  (src_a),
        .src_b  (src_b),
        .busy   (busy),
        .done   (done),
        .result (result),
        .ovf    (ovf)
    );

    function automatic string tag_s(input logic [3:0] t);
        case (t)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Drives one start pulse at a falling edge and waits for done
    task automatic run_op(input logic [63:0] a, input logic [63:0] b,
                          output logic [63:0] res, output logic o, output int cyc);
        @(negedge clk);
        src_a = a;
        src_b = b;
        start = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end while (!done && cyc < 200);
        res = result;
        o = ovf;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        logic [63:0] res;
        logic        o;
        int          cyc;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9", "busy after reset", 64'(busy), 64'd0);
        check("R9", "done after reset", 64'(done), 64'd0);
        check("R9", "result after reset", result, 64'd0);
        check("R9", "ovf after reset", 64'(ovf), 64'd0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            run_op(VECS[i].a, VECS[i].b, res, o, cyc);
            check(tag_s(VECS[i].tag), "result", res, VECS[i].r);
            check(tag_s(VECS[i].tag), "ovf", 64'(o), 64'(VECS[i].o));
            // R7: latency depends on overflow
            check("R7", "latency", 64'(cyc), VECS[i].o ? 64'd1 : 64'(WLEN + 1));
        end

        // R7: busy during the loop, start ignored while busy (R8)
        @(negedge clk);
        src_a = 64'd7;
        src_b = 64'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7", "busy in loop", 64'(busy), 64'd1);
        check("R7", "done low in loop", 64'(done), 64'd0);
        repeat (3) @(negedge clk);
        src_a = 64'd100;
        src_b = 64'd7;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        check("R8", "start while busy ignored", result, 64'd1);
        check("R7", "busy low with done", 64'(busy), 64'd0);
        // R8: start raised in the done cycle is ignored
        src_a = 64'h0000_0000_0000_0005;
        src_b = 64'h0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7", "done single pulse", 64'(done), 64'd0);
        check("R8", "start in done cycle no busy", 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        check("R8", "no done after ignored start", 64'(done), 64'd0);
        check("R8", "result held", result, 64'd1);
        check("R8", "ovf held", 64'(ovf), 64'd0);

        // R9: reset during an operation
        @(negedge clk);
        src_a = 64'h0000_0000_FFFF_FFF9;
        src_b = 64'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9", "busy after mid reset", 64'(busy), 64'd0);
        check("R9", "result after mid reset", result, 64'd0);
        repeat (40) @(negedge clk);
        check("R9", "no late done after reset", 64'(done), 64'd0);

        // R2 then R4: overflow then normal clears the flag
        run_op(64'h0000_0000_0000_0009, 64'h0000_0000_0000_0000, res, o, cyc);
        check("R2", "ovf on zero divisor", 64'(o), 64'd1);
        run_op(64'h0000_0000_0000_0009, 64'h0000_0000_FFFF_FFFC, res, o, cyc);
        check("R4", "9 rem -4", res, 64'd1);
        check("R4", "ovf cleared", 64'(o), 64'd0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule